// File: doc/BRIEF.md
# Multiplexed GPIO Pin Controller

This block controls one bank of general-purpose pins. Each pin can belong to the GPIO logic or to one of four peripheral functions. Each pin has a set of attributes: its owner, its output level, its output enable, open-drain mode, pull-up and pull-down. Software changes an attribute through a pair of strobe addresses. Writing a one to a bit in the "set" word raises that pin's attribute, and writing a one in the "clear" word lowers it. A third address reads the attribute back. Two plain read/write words hold a two-bit function code per pin.

The pad side gets a drive value, a drive enable and the two pull controls for every pin. The block registers the pad levels once per cycle, and software can read them whoever owns the pin. Peripherals present their own drive value and enable per pin. When a peripheral owns a pin, the pair for the selected function reaches the pad. Open-drain mode turns any high drive into a released line.

The register bus has no handshake. A write is taken on every clock edge where the strobe is high. Read data is a combinational function of the address, so there is no back-pressure on either side. Attribute k sits at word addresses 3k (set), 3k+1 (clear) and 3k+2 (status). The attributes are numbered owner=0, output=1, enable=2, open-drain=3, pull-up=4, pull-down=5. The function-code low word is at 18, the high word at 19, and the sampled pad levels at 20.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset every pin is GPIO-owned (owner status reads all ones). All other attribute words, both function words and the pad level read as zero, and pad_oe, pad_pu and pad_pd are all zero.
- R2: Writing ones to address 0 hands those pins to GPIO, and writing ones to address 1 hands them to a peripheral. Address 2 reads 1 for each pin that GPIO owns.
- R3: In a write to any set or clear address, a bit written as zero leaves that pin's attribute unchanged. Writes to status, pad-level or unmapped addresses change nothing.
- R4: Output level is set by ones at address 3 and cleared by ones at address 4, and it reads back at address 5. Each change is visible after the clock edge that takes the write.
- R5: Output enable is set at 6 and cleared at 7, and it reads back at 8. For a GPIO-owned pin with open-drain off, pad_oe equals the enable and pad_do equals the output level.
- R6: Addresses 18 and 19 are plain read/write words. For each pin, the code {word19 bit, word18 bit} selects the function: 0 is A (fn_drive_* index 0), 1 is B (index 1), 2 is C (index 2) and 3 is D (index 3).
- R7: For a peripheral-owned pin with open-drain off, pad_do and pad_oe are that pin's fn_drive_val and fn_drive_en bits of the selected function. They follow those inputs in the same cycle.
- R8: Open-drain is set at 9 and cleared at 10, and it reads back at 11. While it is on, whatever the owner, pad_do is 0 and pad_oe is 1 only when the source enable is 1 and the source value is 0.
- R9: Pull-up is set at 12 and cleared at 13, reading back at 14. Pull-down is set at 15 and cleared at 16, reading back at 17. The two are independent of each other and of the owner, and they drive pad_pu and pad_pd.
- R10: Address 20 returns pad_in as sampled at the previous clock edge, whoever owns the pin.
- R11: Reads of set, clear or unmapped addresses (21 and above) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Combinational read data |
| fn_drive_val | input | 4 x NPINS | Drive value from functions A..D |
| fn_drive_en | input | 4 x NPINS | Drive enable from functions A..D |
| pad_in | input | NPINS | Pad levels |
| pad_do | output | NPINS | Pad drive value |
| pad_oe | output | NPINS | Pad drive enable |
| pad_pu | output | NPINS | Pad pull-up enable |
| pad_pd | output | NPINS | Pad pull-down enable |

## Verification
The bench builds the block with its defaults: a full 32-pin bank and a 5-bit address. The top lane, bit 31, is therefore reachable by every set, clear and select write. The 5-bit address leaves room for the unmapped words 21 to 31, so ignored writes and zero reads can be checked. Random masks make every pin see all four function codes, both owners and open-drain combinations in one run. Directed cases pin down the open-drain release and each function code on a single pin.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int N_ATTR   = 6;
  localparam int ATTR_OWN = 0;
  localparam int ATTR_OUT = 1;
  localparam int ATTR_OE  = 2;
  localparam int ATTR_OD  = 3;
  localparam int ATTR_PU  = 4;
  localparam int ATTR_PD  = 5;
  localparam int N_FUNC   = 4;
  localparam int ADDR_FSEL_LO = 3 * N_ATTR;
  localparam int ADDR_FSEL_HI = 3 * N_ATTR + 1;
  localparam int ADDR_LEVEL   = 3 * N_ATTR + 2;

  function automatic int set_addr(input int k);
    return 3 * k;
  endfunction

  function automatic int clr_addr(input int k);
    return 3 * k + 1;
  endfunction

  function automatic int stat_addr(input int k);
    return 3 * k + 2;
  endfunction
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  logic [W-1:0] set_m, clr_m;

  always_comb begin
    set_m = set_stb ? mask : '0;
    clr_m = clr_stb ? mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= (q | set_m) & ~clr_m;
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_mux_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 bus_addr,
  input  logic                          bus_we,
  input  logic [NPINS-1:0]              bus_wdata,
  input  logic [NPINS-1:0]              level,
  output logic [NPINS-1:0]              bus_rdata,
  output logic [N_ATTR-1:0][NPINS-1:0]  attr_q,
  output logic [NPINS-1:0]              fsel_lo,
  output logic [NPINS-1:0]              fsel_hi
);
  localparam logic [AW-1:0] A_LO  = AW'(ADDR_FSEL_LO);
  localparam logic [AW-1:0] A_HI  = AW'(ADDR_FSEL_HI);
  localparam logic [AW-1:0] A_LVL = AW'(ADDR_LEVEL);

  for (genvar k = 0; k < N_ATTR; k++) begin : g_attr
    localparam logic [AW-1:0] SA = AW'(set_addr(k));
    localparam logic [AW-1:0] CA = AW'(clr_addr(k));
    localparam logic [NPINS-1:0] RV = (k == ATTR_OWN) ? '1 : '0;
    gpio_setclr_reg #(.W(NPINS), .RST_VAL(RV)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (bus_we && bus_addr == SA),
      .clr_stb (bus_we && bus_addr == CA),
      .mask    (bus_wdata),
      .q       (attr_q[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_lo <= '0;
      fsel_hi <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_LO) fsel_lo <= bus_wdata;
      if (bus_addr == A_HI) fsel_hi <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < N_ATTR; k++) begin
      if (bus_addr == AW'(stat_addr(k))) bus_rdata = attr_q[k];
    end
    if (bus_addr == A_LO)  bus_rdata = fsel_lo;
    if (bus_addr == A_HI)  bus_rdata = fsel_hi;
    if (bus_addr == A_LVL) bus_rdata = level;
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_mux_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0]              own_gpio,
  input  logic [NPINS-1:0]              out_lvl,
  input  logic [NPINS-1:0]              out_en,
  input  logic [NPINS-1:0]              od_en,
  input  logic [NPINS-1:0]              fsel_lo,
  input  logic [NPINS-1:0]              fsel_hi,
  input  logic [N_FUNC-1:0][NPINS-1:0]  fn_val,
  input  logic [N_FUNC-1:0][NPINS-1:0]  fn_en,
  output logic [NPINS-1:0]              pad_do,
  output logic [NPINS-1:0]              pad_oe
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [1:0] code;
    logic       src_val, src_en;
    always_comb begin
      code = {fsel_hi[i], fsel_lo[i]};
      if (own_gpio[i]) begin
        src_val = out_lvl[i];
        src_en  = out_en[i];
      end else begin
        src_val = fn_val[code][i];
        src_en  = fn_en[code][i];
      end
      if (od_en[i]) begin
        pad_do[i] = 1'b0;
        pad_oe[i] = src_en & ~src_val;
      end else begin
        pad_do[i] = src_val;
        pad_oe[i] = src_en;
      end
    end
  end
endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 bus_addr,
  input  logic                          bus_we,
  input  logic [NPINS-1:0]              bus_wdata,
  output logic [NPINS-1:0]              bus_rdata,
  input  logic [N_FUNC-1:0][NPINS-1:0]  fn_drive_val,
  input  logic [N_FUNC-1:0][NPINS-1:0]  fn_drive_en,
  input  logic [NPINS-1:0]              pad_in,
  output logic [NPINS-1:0]              pad_do,
  output logic [NPINS-1:0]              pad_oe,
  output logic [NPINS-1:0]              pad_pu,
  output logic [NPINS-1:0]              pad_pd
);
  logic [N_ATTR-1:0][NPINS-1:0] attr_q;
  logic [NPINS-1:0] own_q, dout_q, oe_q, od_q, flo_q, fhi_q, lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= pad_in;
  end

  gpio_regfile #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .level     (lvl_q),
    .bus_rdata (bus_rdata),
    .attr_q    (attr_q),
    .fsel_lo   (flo_q),
    .fsel_hi   (fhi_q)
  );

  assign own_q  = attr_q[ATTR_OWN];
  assign dout_q = attr_q[ATTR_OUT];
  assign oe_q   = attr_q[ATTR_OE];
  assign od_q   = attr_q[ATTR_OD];
  assign pad_pu = attr_q[ATTR_PU];
  assign pad_pd = attr_q[ATTR_PD];

  gpio_pad_mux #(.NPINS(NPINS)) u_mux (
    .own_gpio (own_q),
    .out_lvl  (dout_q),
    .out_en   (oe_q),
    .od_en    (od_q),
    .fsel_lo  (flo_q),
    .fsel_hi  (fhi_q),
    .fn_val   (fn_drive_val),
    .fn_en    (fn_drive_en),
    .pad_do   (pad_do),
    .pad_oe   (pad_oe)
  );
endmodule

// File: rtl/gpio_mux_ctrl_chk.sv
module gpio_mux_ctrl_chk
  import gpio_mux_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [AW-1:0]                 bus_addr,
  input logic                          bus_we,
  input logic [NPINS-1:0]              bus_wdata,
  input logic [NPINS-1:0]              own_q,
  input logic [NPINS-1:0]              dout_q,
  input logic [NPINS-1:0]              oe_q,
  input logic [NPINS-1:0]              od_q,
  input logic [NPINS-1:0]              flo_q,
  input logic [NPINS-1:0]              fhi_q,
  input logic [NPINS-1:0]              lvl_q,
  input logic [NPINS-1:0]              pad_in,
  input logic [N_FUNC-1:0][NPINS-1:0]  fn_drive_val,
  input logic [NPINS-1:0]              pad_do,
  input logic [NPINS-1:0]              pad_oe
);
  localparam logic [AW-1:0] A_OUT_SET = AW'(set_addr(ATTR_OUT));
  localparam logic [AW-1:0] A_OUT_CLR = AW'(clr_addr(ATTR_OUT));

  a_r4_set_or: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OUT_SET) |=> dout_q == ($past(dout_q) | $past(bus_wdata)));

  a_r4_clr_andn: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OUT_CLR) |=> dout_q == ($past(dout_q) & ~$past(bus_wdata)));

  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(own_q) && $stable(dout_q) && $stable(oe_q) && $stable(od_q)
                 && $stable(flo_q) && $stable(fhi_q)));

  a_r8_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    (od_q & pad_oe & pad_do) == '0);

  a_r7_fn_a_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((~own_q & ~od_q & ~flo_q & ~fhi_q) & (pad_do ^ fn_drive_val[0])) == '0);

  a_r10_level_sample: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> lvl_q == $past(pad_in));
endmodule

bind gpio_mux_ctrl gpio_mux_ctrl_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .own_q        (own_q),
  .dout_q       (dout_q),
  .oe_q         (oe_q),
  .od_q         (od_q),
  .flo_q        (flo_q),
  .fhi_q        (fhi_q),
  .lvl_q        (lvl_q),
  .pad_in       (pad_in),
  .fn_drive_val (fn_drive_val),
  .pad_do       (pad_do),
  .pad_oe       (pad_oe)
);

// File: tb/test_gpio_mux_ctrl.sv
module test_gpio_mux_ctrl;
  localparam int NPINS = 32;
  localparam int AW    = 5;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [NPINS-1:0] bus_wdata = '0;
  logic [NPINS-1:0] bus_rdata;
  logic [3:0][NPINS-1:0] fn_drive_val = '0;
  logic [3:0][NPINS-1:0] fn_drive_en = '0;
  logic [NPINS-1:0] pad_in = '0;
  logic [NPINS-1:0] pad_do, pad_oe, pad_pu, pad_pd;

  int checks = 0;
  int errors = 0;

  logic [5:0][NPINS-1:0] m_attr;
  logic [NPINS-1:0] m_lo, m_hi;

  always #(TCLK/2) clk = ~clk;

  gpio_mux_ctrl #(.NPINS(NPINS), .AW(AW)) i_gpio_mux_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fn_drive_val(fn_drive_val), .fn_drive_en(fn_drive_en),
    .pad_in(pad_in), .pad_do(pad_do), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  task automatic chk(input string req, input logic [NPINS-1:0] act,
                     input logic [NPINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NPINS-1:0] exp_read(input int a);
    if (a < 18) return (a % 3 == 2) ? m_attr[a/3] : '0;
    if (a == 18) return m_lo;
    if (a == 19) return m_hi;
    if (a == 20) return pad_in;
    return '0;
  endfunction

  function automatic logic [2*NPINS-1:0] exp_pad();
    logic [NPINS-1:0] d, e;
    for (int i = 0; i < NPINS; i++) begin
      logic v, en;
      int c;
      c = {m_hi[i], m_lo[i]};
      if (m_attr[0][i]) begin v = m_attr[1][i]; en = m_attr[2][i]; end
      else begin v = fn_drive_val[c][i]; en = fn_drive_en[c][i]; end
      if (m_attr[3][i]) begin d[i] = 1'b0; e[i] = en & ~v; end
      else begin d[i] = v; e[i] = en; end
    end
    return {e, d};
  endfunction

  task automatic wr(input int a, input logic [NPINS-1:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    if (a < 18) begin
      if (a % 3 == 0) m_attr[a/3] = m_attr[a/3] | d;
      else if (a % 3 == 1) m_attr[a/3] = m_attr[a/3] & ~d;
    end else if (a == 18) m_lo = d;
    else if (a == 19) m_hi = d;
  endtask

  // R2 R4 R5 R6 R8 R9 R10 R11 status reads; R5 R7 R8 R9 pad outputs
  task automatic check_all(input string tag);
    logic [2*NPINS-1:0] p;
    for (int a = 0; a < 23; a++) begin
      bus_addr = AW'(a);
      #1;
      chk($sformatf("%s R11/R3 read addr %0d", tag, a), bus_rdata, exp_read(a));
    end
    bus_addr = AW'(31);
    #1;
    chk({tag, " R11 addr 31"}, bus_rdata, '0);
    p = exp_pad();
    chk({tag, " R7/R5 pad_do"}, pad_do, p[NPINS-1:0]);
    chk({tag, " R8 pad_oe"}, pad_oe, p[2*NPINS-1:NPINS]);
    chk({tag, " R9 pad_pu"}, pad_pu, m_attr[4]);
    chk({tag, " R9 pad_pd"}, pad_pd, m_attr[5]);
  endtask

  initial begin
    #(TCLK * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    m_attr = '0; m_attr[0] = '1; m_lo = '0; m_hi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_all("R1");
    chk("R1 pad_oe zero", pad_oe, '0);

    // R5 GPIO output on pin 31, R4 set/clear
    wr(3, 32'h8000_0001);
    wr(6, 32'h8000_0000);
    check_all("R5");
    wr(4, 32'h0000_0001);
    check_all("R4");
    // R3 zero bits keep value
    wr(3, 32'h0);
    wr(7, 32'h0);
    check_all("R3");

    // R6 R7 each function code on pin 5
    wr(1, 32'h20);
    fn_drive_val = '0; fn_drive_en = '0;
    for (int c = 0; c < 4; c++) begin
      fn_drive_val[c][5] = 1'b1; fn_drive_en[c][5] = 1'b1;
    end
    for (int c = 0; c < 4; c++) begin
      wr(18, (c & 1) ? 32'h20 : 32'h0);
      wr(19, (c & 2) ? 32'h20 : 32'h0);
      fn_drive_val[c][5] = 1'b0;
      #1;
      chk($sformatf("R6 code %0d pad_do bit5", c), {31'b0, pad_do[5]}, 32'h0);
      chk($sformatf("R7 code %0d pad_oe bit5", c), {31'b0, pad_oe[5]}, 32'h1);
      fn_drive_val[c][5] = 1'b1;
    end

    // R8 open-drain release on GPIO pin 31 driving high
    wr(0, 32'h8000_0000);
    wr(9, 32'h8000_0000);
    check_all("R8");
    chk("R8 released high", pad_oe & 32'h8000_0000, '0);
    wr(4, 32'h8000_0000);
    check_all("R8b");
    chk("R8 pulls low", pad_oe & 32'h8000_0000, 32'h8000_0000);

    // R10 pad level independent of owner
    pad_in = 32'hA5A5_5A5A;
    @(negedge clk);
    check_all("R10");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int a;
      a = $urandom_range(0, 23);
      fn_drive_val = {$urandom, $urandom, $urandom, $urandom};
      fn_drive_en  = {$urandom, $urandom, $urandom, $urandom};
      pad_in = $urandom;
      wr(a, $urandom);
      check_all("RND");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule